// File: doc/BRIEF.md
# DDR Pseudo-Static RAM Burst Master

This block is the controller side of a narrow double-data-rate memory link. It runs one read or one write burst at a time to a self-refreshing pseudo-static RAM over an 8-bit shared data bus. The link has a single active-low select, a bus clock, and a bidirectional strobe line. Each transaction starts with a 48-bit command word sent on the data lines. The engine then waits out the initial latency. While the command goes out, it watches the strobe line: if the memory holds the strobe high, a hidden refresh is pending and the wait is doubled.

In the data phase the strobe line has two roles. On a read it belongs to the memory, and every transition marks one valid byte. On a write the engine drives it as a per-byte mask while it streams the bytes. A read in which the strobe stops toggling is abandoned after a bounded wait and reported as an error.

The model runs in one clock domain at twice the bus clock rate, so each rising edge of `clk` is one bus edge and carries one byte. On the user side there is a request port with a ready signal, a byte-stream write port that takes one byte per cycle, a byte-stream read port, and a completion pulse with an error flag. A request length must be at least 1.

Top module: `hbus_xfer_engine`

## Requirements
- R1: While reset is held and in the first cycle after it is released, bus_cs_n=1, bus_ck=0, bus_dq_oe=0, bus_rwds_oe=0, req_ready=1, done=0 and wr_take=0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. In the next six cycles bus_cs_n=0, bus_dq_oe=1, and bus_dq_out carries the 48-bit command word, most significant byte first. In that word, bit 47 is 1 for a read and 0 for a write, bit 46 is 0 (memory space), bit 45 is req_linear (1 = linear, 0 = wrapped), and bits 44:0 hold req_addr zero-extended.
- R3: If bus_rwds_in is sampled high in any of the six command cycles, the latency phase lasts 4*LAT_CLKS cycles; otherwise it lasts 2*LAT_CLKS cycles. During the latency phase bus_cs_n=0, bus_dq_oe=0 and bus_rwds_oe=0.
- R4: A write moves req_len bytes, one per cycle. In each of these cycles wr_take=1, bus_dq_oe=1, bus_dq_out=wr_data, bus_rwds_oe=1 and bus_rwds_out=wr_mask (1 = byte not written, 0 = byte written).
- R5: During a read data phase, every cycle in which bus_rwds_in differs from its value in the previous cycle delivers one byte: rd_valid=1 and rd_data=bus_dq_in in that same cycle. In read cycles without a strobe transition, rd_valid=0.
- R6: After the last byte of a transaction, the next cycle shows done=1 with err=0 and bus_cs_n=1. Strobe pauses of up to 2*TIMEOUT_CLKS-1 consecutive cycles within a read are tolerated.
- R7: If a read sees 2*TIMEOUT_CLKS consecutive data cycles without a strobe transition, it is aborted. The next cycle shows done=1 with err=1 and bus_cs_n=1.
- R8: After done, bus_cs_n stays high for at least three cycles, and req_ready returns in the third of them.
- R9: While bus_cs_n is low, bus_ck toggles every cycle, starting at 0 in the first command cycle. While bus_cs_n is high, bus_ck is 0.
- R10: req_valid asserted while a transaction is in flight (req_ready=0) has no effect. Once the transaction completes, no new command phase starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus clock rate |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request may be accepted |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_linear | input | 1 | 1 = linear burst, 0 = wrapped |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Number of bytes, at least 1 |
| wr_data | input | 8 | Write byte currently offered |
| wr_mask | input | 1 | 1 = do not write this byte |
| wr_take | output | 1 | Offered write byte consumed this cycle |
| rd_valid | output | 1 | Read byte valid this cycle |
| rd_data | output | 8 | Read byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Read timed out (valid with done) |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_ck | output | 1 | Bus clock |
| bus_dq_out | output | 8 | Data lines, driven value |
| bus_dq_oe | output | 1 | Data lines output enable |
| bus_dq_in | input | 8 | Data lines, received value |
| bus_rwds_out | output | 1 | Strobe line, driven value (write mask) |
| bus_rwds_oe | output | 1 | Strobe line output enable |
| bus_rwds_in | input | 1 | Strobe line, received value |

## Verification
The critical coincidence is a strobe transition that arrives in the same cycle in which the stall counter reaches its limit. In that cycle the byte capture and the timeout abort are both eligible. The bench provokes this with a read that pauses for 2*TIMEOUT_CLKS-1 cycles and then toggles the strobe on the next cycle. It passes only if the byte is delivered, the burst completes and err stays low. A companion read that pauses one cycle longer must abort after exactly 2*TIMEOUT_CLKS stalled cycles.

// File: rtl/hbx_pkg.sv
// Shared constants, state type and command-word builder for the burst master.
// Assumes an 8-bit data bus and a 48-bit command word.
package hbx_pkg;
    localparam int BYTE_W       = 8;
    localparam int CA_W         = 48;
    localparam int CA_BYTES     = CA_W / BYTE_W;
    localparam int CA_RD_BIT    = 47;
    localparam int CA_SPACE_BIT = 46;
    localparam int CA_LIN_BIT   = 45;
    localparam int CA_ADDR_W    = 45;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CA,
        ST_LAT,
        ST_DATA,
        ST_END
    } hbx_state_t;

    // Assemble the command word from direction, burst type and address.
    function automatic logic [CA_W-1:0] ca_word(input logic is_read,
                                                 input logic linear,
                                                 input logic [CA_ADDR_W-1:0] addr);
        logic [CA_W-1:0] w;
        w               = '0;
        w[CA_ADDR_W-1:0] = addr;
        w[CA_RD_BIT]    = is_read;
        w[CA_SPACE_BIT] = 1'b0;
        w[CA_LIN_BIT]   = linear;
        return w;
    endfunction
endpackage

// File: rtl/hbx_ca_shift.sv
// Command-word shifter: loads the whole word at request acceptance and
// presents it one byte per cycle, most significant byte first.
// Assumes W is a whole number of B-bit bytes.
module hbx_ca_shift #(
    parameter int W = 48,
    parameter int B = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] word_in,
    output logic [B-1:0] byte_out
);
    logic [W-1:0] sh;

    // Load on accept, shift one byte per command cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     sh <= '0;
        else if (load)  sh <= word_in;
        else if (shift) sh <= {sh[W-B-1:0], {B{1'b0}}};
    end

    assign byte_out = sh[W-1 -: B];
endmodule

// File: rtl/hbx_rd_capture.sv
// Read-strobe capture: flags a byte in every enabled cycle whose strobe level
// differs from the previous cycle, and raises a timeout after TO_EDGES
// consecutive enabled cycles without a transition.
// Assumes strobe and data arrive settled in this clock domain.
module hbx_rd_capture #(
    parameter int TO_EDGES = 8,
    parameter int B        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         rwds_in,
    input  logic [B-1:0] dq_in,
    output logic         rd_valid,
    output logic [B-1:0] rd_data,
    output logic         timeout
);
    localparam int TO_W = $clog2(TO_EDGES + 1);

    logic            rwds_q;
    logic            rx_edge;
    logic [TO_W-1:0] to_cnt;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rwds_q <= 1'b0;
        else        rwds_q <= rwds_in;
    end

    assign rx_edge  = rwds_in ^ rwds_q;
    assign rd_valid = en & rx_edge;
    assign rd_data  = dq_in;
    assign timeout  = en & ~rx_edge & (to_cnt == TO_W'(TO_EDGES - 1));

    // Count enabled cycles since the last strobe transition.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || rx_edge) to_cnt <= '0;
        else if (!timeout)            to_cnt <= to_cnt + 1'b1;
    end

    a_r7_stall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (to_cnt == '0));
    a_r7_stall_bound: assert property (@(posedge clk) disable iff (!rst_n)
        to_cnt < TO_W'(TO_EDGES));
endmodule

// File: rtl/hbus_xfer_engine.sv
// Burst master for a DDR pseudo-static RAM link. Runs one read or write burst
// per request: command phase, refresh-dependent latency, data phase, deselect.
// Assumes clk runs at twice the bus rate (one byte per clk) and req_len >= 1.
module hbus_xfer_engine
    import hbx_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int LEN_W        = 8,
    parameter int LAT_CLKS     = 3,
    parameter int TIMEOUT_CLKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_linear,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        wr_data,
    input  logic              wr_mask,
    output logic              wr_take,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic              err,
    output logic              bus_cs_n,
    output logic              bus_ck,
    output logic [7:0]        bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [7:0]        bus_dq_in,
    output logic              bus_rwds_out,
    output logic              bus_rwds_oe,
    input  logic              bus_rwds_in
);
    localparam int LAT_ONE  = 2 * LAT_CLKS;
    localparam int LAT_TWO  = 4 * LAT_CLKS;
    localparam int TO_EDGES = 2 * TIMEOUT_CLKS;
    localparam int CNT_MAX  = (LAT_TWO > (1 << LEN_W)) ? LAT_TWO : (1 << LEN_W);
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    hbx_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] len_q;
    logic             is_wr;
    logic             dbl;
    logic             err_q;
    logic             ph;
    logic             accept;
    logic             active;
    logic             wr_phase;
    logic             rx_en;
    logic             rx_timeout;
    logic [7:0]       ca_byte;
    logic [CNT_W-1:0] lat_last;
    logic [CNT_W-1:0] len_last;

    assign accept   = (state == ST_IDLE) && req_valid;
    assign active   = (state == ST_CA) || (state == ST_LAT) || (state == ST_DATA);
    assign wr_phase = (state == ST_DATA) && is_wr;
    assign rx_en    = (state == ST_DATA) && !is_wr;
    assign lat_last = dbl ? CNT_W'(LAT_TWO - 1) : CNT_W'(LAT_ONE - 1);
    assign len_last = CNT_W'(len_q) - 1'b1;

    hbx_ca_shift #(.W(CA_W), .B(BYTE_W)) u_ca (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .shift    (state == ST_CA),
        .word_in  (ca_word(!req_write, req_linear, CA_ADDR_W'(req_addr))),
        .byte_out (ca_byte)
    );

    hbx_rd_capture #(.TO_EDGES(TO_EDGES), .B(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .rwds_in  (bus_rwds_in),
        .dq_in    (bus_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .timeout  (rx_timeout)
    );

    // Transaction sequencer: phase changes, per-phase counter, latency choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            len_q <= '0;
            is_wr <= 1'b0;
            dbl   <= 1'b0;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state <= ST_CA;
                    cnt   <= '0;
                    len_q <= req_len;
                    is_wr <= req_write;
                    dbl   <= 1'b0;
                    err_q <= 1'b0;
                end
                ST_CA: begin
                    dbl <= dbl | bus_rwds_in;
                    if (cnt == CNT_W'(CA_BYTES - 1)) begin
                        state <= ST_LAT;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_LAT: begin
                    if (cnt == lat_last) begin
                        state <= ST_DATA;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_DATA: begin
                    if (!is_wr && rx_timeout) begin
                        err_q <= 1'b1;
                        state <= ST_END;
                        cnt   <= '0;
                    end else if (is_wr || rd_valid) begin
                        if (cnt == len_last) begin
                            state <= ST_END;
                            cnt   <= '0;
                        end else cnt <= cnt + 1'b1;
                    end
                end
                ST_END: begin
                    if (cnt == CNT_W'(1)) begin
                        state <= ST_IDLE;
                        cnt   <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus clock phase: toggles every cycle while selected, parked low otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= active ? ~ph : 1'b0;
    end

    assign req_ready    = (state == ST_IDLE);
    assign bus_cs_n     = !active;
    assign bus_ck       = active & ph;
    assign bus_dq_oe    = (state == ST_CA) || wr_phase;
    assign bus_dq_out   = (state == ST_CA) ? ca_byte : (wr_phase ? wr_data : 8'h00);
    assign bus_rwds_oe  = wr_phase;
    assign bus_rwds_out = wr_phase & wr_mask;
    assign wr_take      = wr_phase;
    assign done         = (state == ST_END) && (cnt == '0);
    assign err          = done & err_q;

    a_r8_deselect_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |=> bus_cs_n);
    a_r3_latency_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LAT) |-> (!bus_dq_oe && !bus_rwds_oe && !bus_cs_n));
    a_r7_timeout_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && rx_timeout) |=> (done && err));
    a_r5_no_rx_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !is_wr);
    a_r2_select_drives_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> (bus_dq_oe && !bus_rwds_oe));
    a_r6_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_cs_n && !req_ready));
endmodule

// File: tb/hbus_xfer_engine_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module hbus_xfer_engine_bench;
    localparam int LATC = 3;
    localparam int TOC  = 4;
    localparam int TOE  = 2 * TOC;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write, req_linear;
    logic [31:0] req_addr;
    logic [7:0]  req_len;
    logic [7:0]  wr_data;
    logic        wr_mask, wr_take, rd_valid, done, err;
    logic [7:0]  rd_data;
    logic        bus_cs_n, bus_ck, bus_dq_oe, bus_rwds_out, bus_rwds_oe, bus_rwds_in;
    logic [7:0]  bus_dq_out, bus_dq_in;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hbus_xfer_engine #(.LAT_CLKS(LATC), .TIMEOUT_CLKS(TOC)) u_hbus_xfer_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_linear(req_linear), .req_addr(req_addr),
        .req_len(req_len), .wr_data(wr_data), .wr_mask(wr_mask), .wr_take(wr_take),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done), .err(err),
        .bus_cs_n(bus_cs_n), .bus_ck(bus_ck), .bus_dq_out(bus_dq_out),
        .bus_dq_oe(bus_dq_oe), .bus_dq_in(bus_dq_in), .bus_rwds_out(bus_rwds_out),
        .bus_rwds_oe(bus_rwds_oe), .bus_rwds_in(bus_rwds_in)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] ca_byte(input bit wr, input bit lin,
                                           input logic [31:0] a, input int k);
        logic [47:0] w;
        w = {~wr, 1'b0, lin, 13'd0, a};
        return w[47 - 8*k -: 8];
    endfunction

    // Accept a request and check the six command bytes (R2, R9).
    task automatic send_cmd(input bit wr, input bit lin, input logic [31:0] a,
                            input int len, input bit refresh);
        @(negedge clk);
        chk("R8 ready before request", req_ready, 1);
        req_valid = 1; req_write = wr; req_linear = lin; req_addr = a; req_len = 8'(len);
        @(posedge clk); #1;
        req_valid = 0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            bus_rwds_in = refresh;
            chk("R2 select low", bus_cs_n, 0);
            chk("R2 dq driven", bus_dq_oe, 1);
            chk("R2 command byte", bus_dq_out, ca_byte(wr, lin, a, k));
            chk("R9 ck toggle", bus_ck, 64'(k % 2));
        end
    endtask

    // Completion and deselect gap (R6, R7, R8, R9).
    task automatic end_check(input bit exp_err);
        chk("R6 done pulse", done, 1);
        chk(exp_err ? "R7 err flag" : "R6 err clear", err, 64'(exp_err));
        chk("R8 select high", bus_cs_n, 1);
        chk("R9 ck parked", bus_ck, 0);
        @(negedge clk);
        chk("R8 gap cycle 2", bus_cs_n, 1);
        chk("R6 single done", done, 0);
        @(negedge clk);
        chk("R8 gap cycle 3", bus_cs_n, 1);
        chk("R8 ready again", req_ready, 1);
    endtask

    task automatic do_write(input logic [31:0] a, input int len, input bit lin,
                            input bit refresh, input bit poke);
        int lat = 0;
        send_cmd(1, lin, a, len, refresh);
        wr_data = a[7:0]; wr_mask = 0;
        @(negedge clk);
        bus_rwds_in = 0;
        while (!wr_take && lat < 64) begin
            chk("R3 latency quiet", {bus_dq_oe, bus_rwds_oe, bus_cs_n}, 0);
            if (poke && lat == 0) begin req_valid = 1; req_addr = 32'hDEAD; end
            if (poke && lat == 1) req_valid = 0;
            lat++;
            @(negedge clk);
        end
        req_valid = 0;
        chk("R3 latency length", 64'(lat), 64'(refresh ? 4*LATC : 2*LATC));
        for (int i = 0; i < len; i++) begin
            wr_data = a[7:0] ^ 8'(i * 37);
            wr_mask = (i % 3 == 1);
            #1;
            chk("R4 take", wr_take, 1);
            chk("R4 data", bus_dq_out, 64'(a[7:0] ^ 8'(i * 37)));
            chk("R4 mask", {bus_rwds_oe, bus_rwds_out}, {1'b1, (i % 3 == 1)});
            @(negedge clk);
        end
        chk("R4 take ends", wr_take, 0);
        end_check(0);
        if (poke) begin
            for (int j = 0; j < 4; j++) begin
                @(negedge clk);
                chk("R10 busy request ignored", bus_cs_n, 1);
            end
        end
    endtask

    // Read with an optional strobe pause before byte gap_at (R5, R6).
    task automatic do_read(input logic [31:0] a, input int len, input bit lin,
                           input bit refresh, input int gap_at, input int gap_len);
        logic r = 0;
        send_cmd(0, lin, a, len, refresh);
        for (int j = 0; j < (refresh ? 4*LATC : 2*LATC); j++) begin
            @(negedge clk);
            bus_rwds_in = 0;
            chk("R3 read latency quiet", {bus_dq_oe, bus_rwds_oe, bus_cs_n, done}, 0);
        end
        for (int i = 0; i < len; i++) begin
            if (i == gap_at) begin
                for (int g = 0; g < gap_len; g++) begin
                    @(negedge clk); #1;
                    chk("R5 no byte without edge", rd_valid, 0);
                end
            end
            @(negedge clk);
            r = ~r; bus_rwds_in = r; bus_dq_in = a[7:0] + 8'(i * 11);
            #1;
            chk("R5 valid on edge", rd_valid, 1);
            chk("R5 byte", rd_data, 64'(a[7:0] + 8'(i * 11)));
        end
        @(negedge clk);
        end_check(0);
    endtask

    // Read whose strobe stops after nbytes: abort after TOE stalled cycles (R7).
    task automatic do_timeout(input int nbytes);
        logic r = 0;
        send_cmd(0, 1, 32'h40, 8, 0);
        for (int j = 0; j < 2*LATC; j++) begin
            @(negedge clk);
            bus_rwds_in = 0;
        end
        for (int i = 0; i < nbytes; i++) begin
            @(negedge clk);
            r = ~r; bus_rwds_in = r; bus_dq_in = 8'(i);
            #1;
            chk("R5 pre-stall byte", rd_valid, 1);
        end
        for (int g = 0; g < TOE; g++) begin
            @(negedge clk);
            chk("R7 still waiting", {done, bus_cs_n}, 0);
        end
        @(negedge clk);
        end_check(1);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_linear = 0; req_addr = '0;
        req_len = '0; wr_data = '0; wr_mask = 0; bus_dq_in = '0; bus_rwds_in = 0;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1 reset outputs", {bus_cs_n, bus_ck, bus_dq_oe, bus_rwds_oe, req_ready, done, wr_take},
            7'b1000100);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {bus_cs_n, bus_ck, bus_dq_oe, bus_rwds_oe, req_ready, done, wr_take},
            7'b1000100);
        do_write(32'h0012_3456, 5, 1, 0, 0);
        do_write(32'h00AB_CDEF, 4, 0, 1, 0);
        do_read (32'h0000_0F00, 6, 0, 0, 99, 0);
        do_read (32'h0765_4321, 3, 1, 1, 99, 0);
        do_read (32'h0000_0100, 4, 1, 0, 2, 3);
        do_read (32'h0000_0200, 3, 1, 0, 1, TOE - 1);
        do_timeout(0);
        do_timeout(2);
        do_write(32'h0000_0033, 1, 1, 0, 1);
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        report();
    end
endmodule